// File: doc/BRIEF.md
# Multi-mode 8-bit timer with PWM

The block is a single-channel 8-bit timer/counter with one compare channel and one waveform output. A clock-select field chooses where count ticks come from: nothing (stopped), one of five taps of a free-running 10-bit prescaler, or either edge of an external event pin. The pin passes through a synchronizer and an edge detector. A two-bit mode field picks one of four behaviours. Free-running counting wraps at 0xFF. Clear-on-match counting lets the compare value set the period. Phase-correct PWM counts up to 0xFF and back down to 0x00. Toggle mode clears on match like clear-on-match and also flips the output, so it acts as a frequency generator.

Two events are latched as flags: counter overflow and compare match. Each flag is gated by its own mask bit onto an interrupt request line. Software reaches the count, the compare value, the control fields, the flags and the masks through a small register-style port. A write takes effect on the clock edge where `regWr` is high. Reads are combinational from `regAddr`. In PWM mode the compare value is double-buffered, and the active copy is refreshed only at the top of the count, so a duty change never makes a glitch. The waveform output is always a registered signal.

Top module: `tmr8_top`

## Requirements
- R1: After reset, every readable register (control, count, compare, flags, masks) reads 0x00, both interrupt lines are low and `waveOut` is low.
- R2: The control field `clkSel` selects the count tick. 0 means no tick, so the counter holds. Values 1, 2, 3, 4 and 5 give a tick on every cycle in which the low 0, 3, 6, 8 or 10 bits of a free-running 10-bit prescaler (reset to 0, +1 per cycle) are all ones. Value 6 counts falling edges of `extPin` and value 7 counts rising edges. The pin passes through a 2-flop synchronizer and then an edge detector, so the counter moves on the second clock edge after the edge that first samples the new pin level.
- R3: In free mode (mode 0) each tick adds 1 to the count. A tick at count 0xFF wraps the count to 0x00 and sets the overflow flag.
- R4: In clear-on-match mode (mode 1), a tick while the count equals the active compare value loads 0x00; any other tick adds 1. A tick at 0xFF that is not a match wraps the count and sets the overflow flag.
- R5: In PWM mode (mode 2) the count runs 0,1,…,0xFF,0xFE,…,1,0,1,…. A tick at 0xFF while counting up turns the count down to 0xFE. A tick at 0x00 while counting down turns it up to 0x01 and sets the overflow flag. Leaving PWM mode restores the up direction.
- R6: In PWM mode, a compare match on an up-counting tick drives `waveOut` to the value of the invert bit, and a match on a down-counting tick drives it to the complement of that bit. The output changes only on ticks, and free mode and clear-on-match mode leave it unchanged.
- R7: A compare write always updates the readable buffer. Outside PWM mode the active compare value follows the buffer at once. In PWM mode the active value takes the buffer's content only on the tick at 0xFF while counting up.
- R8: In toggle mode (mode 3) the count behaves as in R4, and every compare match inverts `waveOut`.
- R9: In every mode, a tick taken while the count equals the active compare value sets the compare flag.
- R10: Writing the flags register clears each flag whose data bit is 1 (bit 0 overflow, bit 1 compare). A high `ackOvf` or `ackCmp` also clears that flag. A flag being set in the same cycle wins over any clear.
- R11: `irqOvf` is the overflow flag ANDed with mask bit 0, and `irqCmp` is the compare flag ANDed with mask bit 1.
- R12: A count write loads the written value on that edge in place of the tick's action. No overflow or match event comes from that cycle's tick.
- R13: Register map: address 0 is control ([2:0] clkSel, [4:3] mode, [5] invert, other bits read 0), 1 is count, 2 is compare buffer, 3 is flags ([0] overflow, [1] compare), 4 is masks ([0] overflow, [1] compare). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` |
| extPin | input | 1 | External event input |
| ackOvf | input | 1 | Overflow interrupt acknowledge |
| ackCmp | input | 1 | Compare interrupt acknowledge |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmp | output | 1 | Compare interrupt request |
| waveOut | output | 1 | Waveform output |

## Verification
A flag can be set by the counter in the same cycle that software writes a 1 to clear it or an acknowledge arrives. The set must win. A directed case stops the counter at 0xFF, then restarts it with a single-cycle divider and writes the flag clear on exactly the edge of the wrap. The flag must read back as 1, and a second clear on a quiet edge must then empty it. Random traffic adds further collisions of the same kind, for both flags and for both the acknowledges and the register clear, and it also makes count writes land on tick edges. A cycle model in the bench, built from the requirements, judges every one of them by comparing read data, interrupt lines and the output on every cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_CLEAR  = 2'd1,
    MODE_PWM    = 2'd2,
    MODE_TOGGLE = 2'd3
  } tmrMode_e;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_CMP   = 3'd2;
  localparam logic [2:0] ADDR_FLAGS = 3'd3;
  localparam logic [2:0] ADDR_MASK  = 3'd4;

  // strobes from control to datapath, all valid for one edge
  typedef struct packed {
    logic tick;
    logic wrCount;
    logic wrCompare;
    logic clrOvf;
    logic clrCmp;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int PRESC_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [5:0]        cfgData,
  input  logic              extPin,
  input  logic              ackOvf,
  input  logic              ackCmp,
  output tmrStrobe_t        strobe,
  output tmrMode_e          mode,
  output logic              invert,
  output logic [2:0]        clkSel,
  output logic              maskOvf,
  output logic              maskCmp
);

  // prescaler tap widths for clock-select codes 2..5
  localparam int TAP_A = 3;
  localparam int TAP_B = 6;
  localparam int TAP_C = 8;
  localparam int TAP_D = (PRESC_W < 10) ? PRESC_W : 10;

  logic [PRESC_W-1:0]     presc;
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   edgePrev;
  logic                   riseEv;
  logic                   fallEv;
  logic                   wrCtrl;
  logic                   wrMask;
  logic                   wrFlags;
  logic                   tickSel;

  function automatic logic tapHit(input logic [PRESC_W-1:0] p, input int k);
    logic [PRESC_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRESC_W; i++) begin
      if (i < k) m[i] = 1'b1;
    end
    return ((p & m) == m);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end

  // synchronizer chain for the external event pin
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= extPin;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b0;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgePrev <= 1'b0;
    else       edgePrev <= syncReg[SYNC_STAGES-1];
  end

  assign riseEv = syncReg[SYNC_STAGES-1] & ~edgePrev;
  assign fallEv = ~syncReg[SYNC_STAGES-1] & edgePrev;

  always_comb begin
    case (clkSel)
      3'd0:    tickSel = 1'b0;
      3'd1:    tickSel = 1'b1;
      3'd2:    tickSel = tapHit(presc, TAP_A);
      3'd3:    tickSel = tapHit(presc, TAP_B);
      3'd4:    tickSel = tapHit(presc, TAP_C);
      3'd5:    tickSel = tapHit(presc, TAP_D);
      3'd6:    tickSel = fallEv;
      default: tickSel = riseEv;
    endcase
  end

  assign wrCtrl  = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrMask  = regWr && (regAddr == ADDR_W'(ADDR_MASK));
  assign wrFlags = regWr && (regAddr == ADDR_W'(ADDR_FLAGS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel  <= 3'd0;
      mode    <= MODE_FREE;
      invert  <= 1'b0;
      maskOvf <= 1'b0;
      maskCmp <= 1'b0;
    end else begin
      if (wrCtrl) begin
        clkSel <= cfgData[2:0];
        mode   <= tmrMode_e'(cfgData[4:3]);
        invert <= cfgData[5];
      end
      if (wrMask) begin
        maskOvf <= cfgData[0];
        maskCmp <= cfgData[1];
      end
    end
  end

  always_comb begin
    strobe.tick      = tickSel;
    strobe.wrCount   = regWr && (regAddr == ADDR_W'(ADDR_COUNT));
    strobe.wrCompare = regWr && (regAddr == ADDR_W'(ADDR_CMP));
    strobe.clrOvf    = (wrFlags && cfgData[0]) || ackOvf;
    strobe.clrCmp    = (wrFlags && cfgData[1]) || ackCmp;
  end

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |-> !strobe.tick);  // R2

  AST_EXT_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd7 && $past(clkSel) == 3'd7 && $rose(syncReg[SYNC_STAGES-1])) |-> strobe.tick);  // R2

endmodule

// File: rtl/tmr8_dp.sv
module tmr8_dp
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  tmrMode_e         mode,
  input  logic             invert,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpBuf,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             waveOut
);

  localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  logic [CNT_W-1:0] cmpAct;
  logic             countUp;
  logic             active;
  logic             hit;
  logic             atTop;
  logic             atBottom;
  logic             ovfSet;
  logic             cmpSet;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] cmpActNext;
  logic             upNext;
  logic             waveNext;

  always_comb begin
    active   = strobe.tick && !strobe.wrCount;
    hit      = active && (count == cmpAct);
    atTop    = active && (mode == MODE_PWM) && countUp && (count == TOP);
    atBottom = active && (mode == MODE_PWM) && !countUp && (count == BOTTOM);
    ovfSet   = (active && (mode != MODE_PWM) && (count == TOP)) || atBottom;
    cmpSet   = hit;
  end

  always_comb begin
    countNext = count;
    if (strobe.wrCount) begin
      countNext = wdata;
    end else if (active) begin
      case (mode)
        MODE_FREE: countNext = count + 1'b1;
        MODE_CLEAR, MODE_TOGGLE: countNext = hit ? BOTTOM : count + 1'b1;
        default: begin
          if (countUp) countNext = (count == TOP) ? TOP - 1'b1 : count + 1'b1;
          else         countNext = (count == BOTTOM) ? BOTTOM + 1'b1 : count - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    upNext = countUp;
    if (mode != MODE_PWM) upNext = 1'b1;
    else if (atTop)       upNext = 1'b0;
    else if (atBottom)    upNext = 1'b1;
  end

  always_comb begin
    cmpActNext = cmpAct;
    if (mode != MODE_PWM) cmpActNext = strobe.wrCompare ? wdata : cmpBuf;
    else if (atTop)       cmpActNext = cmpBuf;
  end

  always_comb begin
    waveNext = waveOut;
    if (hit) begin
      if (mode == MODE_TOGGLE)   waveNext = ~waveOut;
      else if (mode == MODE_PWM) waveNext = countUp ? invert : ~invert;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      cmpBuf  <= '0;
      cmpAct  <= '0;
      countUp <= 1'b1;
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
      waveOut <= 1'b0;
    end else begin
      count   <= countNext;
      cmpAct  <= cmpActNext;
      countUp <= upNext;
      waveOut <= waveNext;
      if (strobe.wrCompare) cmpBuf <= wdata;
      ovfFlag <= ovfSet || (ovfFlag && !strobe.clrOvf);
      cmpFlag <= cmpSet || (cmpFlag && !strobe.clrCmp);
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.wrCount) |=> $stable(count));  // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCount |=> (count == $past(wdata) && !$rose(ovfFlag)));  // R12

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_CLEAR || mode == MODE_TOGGLE) && active && count == cmpAct) |=> count == BOTTOM);  // R4

  AST_PWM_TURN_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PWM && active && countUp && count == TOP) |=> (count == TOP - 1'b1 && !countUp));  // R5

  AST_PWM_TURN_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PWM && active && !countUp && count == BOTTOM) |=> (count == BOTTOM + 1'b1 && ovfFlag));  // R5

  AST_WAVE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(waveOut));  // R6

  AST_PWM_CMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PWM && !(active && countUp && count == TOP)) |=> $stable(cmpAct));  // R7

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ovfSet |=> ovfFlag);  // R10

  AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmpSet |=> cmpFlag);  // R10

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int PRESC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              extPin,
  input  logic              ackOvf,
  input  logic              ackCmp,
  output logic              irqOvf,
  output logic              irqCmp,
  output logic              waveOut
);

  tmrStrobe_t        strobe;
  tmrMode_e          mode;
  logic              invert;
  logic [2:0]        clkSel;
  logic              maskOvf;
  logic              maskCmp;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] cmpBuf;
  logic              ovfFlag;
  logic              cmpFlag;

  tmr8_ctrl #(
    .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .SYNC_STAGES(2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .cfgData(regWdata[5:0]), .extPin(extPin), .ackOvf(ackOvf), .ackCmp(ackCmp),
    .strobe(strobe), .mode(mode), .invert(invert), .clkSel(clkSel),
    .maskOvf(maskOvf), .maskCmp(maskCmp)
  );

  tmr8_dp #(.CNT_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .invert(invert),
    .wdata(regWdata), .count(count), .cmpBuf(cmpBuf),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .waveOut(waveOut)
  );

  assign irqOvf = ovfFlag && maskOvf;
  assign irqCmp = cmpFlag && maskCmp;

  always_comb begin
    case (regAddr)
      ADDR_W'(ADDR_CTRL):  regRdata = DATA_W'({invert, mode, clkSel});
      ADDR_W'(ADDR_COUNT): regRdata = count;
      ADDR_W'(ADDR_CMP):   regRdata = cmpBuf;
      ADDR_W'(ADDR_FLAGS): regRdata = DATA_W'({cmpFlag, ovfFlag});
      ADDR_W'(ADDR_MASK):  regRdata = DATA_W'({maskCmp, maskOvf});
      default:             regRdata = '0;
    endcase
  end

endmodule

// File: tb/tmr8_top_test.sv
`timescale 1ns/1ps
module tmr8_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       extPin = 1'b0;
  logic       ackOvf = 1'b0;
  logic       ackCmp = 1'b0;
  logic       irqOvf;
  logic       irqCmp;
  logic       waveOut;

  int  checks = 0;
  int  failures = 0;
  bit  checkEn = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  tmr8_top uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extPin(extPin),
    .ackOvf(ackOvf), .ackCmp(ackCmp), .irqOvf(irqOvf), .irqCmp(irqCmp),
    .waveOut(waveOut)
  );

  // reference model state, built from the requirements
  logic [9:0] mPresc;
  logic       mS1, mS2, mS3;
  logic [2:0] mSel;
  logic [1:0] mMode;
  logic       mInv;
  logic       mMaskO, mMaskC;
  logic [7:0] mCnt, mBuf, mAct;
  logic       mUp, mOvf, mCmpF, mOut;

  function automatic logic tapOk(input logic [9:0] p, input int k);
    logic [9:0] m;
    m = 10'((1 << k) - 1);
    return ((p & m) == m);
  endfunction

  function automatic logic mTick();
    case (mSel)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return tapOk(mPresc, 3);
      3'd3: return tapOk(mPresc, 6);
      3'd4: return tapOk(mPresc, 8);
      3'd5: return tapOk(mPresc, 10);
      3'd6: return !mS2 && mS3;
      default: return mS2 && !mS3;
    endcase
  endfunction

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return {2'b00, mInv, mMode, mSel};
      3'd1: return mCnt;
      3'd2: return mBuf;
      3'd3: return {6'd0, mCmpF, mOvf};
      3'd4: return {6'd0, mMaskC, mMaskO};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPresc = '0; mS1 = 0; mS2 = 0; mS3 = 0;
      mSel = 0; mMode = 0; mInv = 0; mMaskO = 0; mMaskC = 0;
      mCnt = 0; mBuf = 0; mAct = 0; mUp = 1; mOvf = 0; mCmpF = 0; mOut = 0;
    end else begin
      logic tk, wc, wk, wf, act, hit, top, bot, ovs;
      logic [7:0] nCnt, nAct, nBuf;
      logic nUp, nOut, clrO, clrC;
      tk  = mTick();
      wc  = regWr && regAddr == 3'd1;
      wk  = regWr && regAddr == 3'd2;
      wf  = regWr && regAddr == 3'd3;
      act = tk && !wc;
      hit = act && mCnt == mAct;
      top = act && mMode == 2 && mUp && mCnt == 8'hFF;
      bot = act && mMode == 2 && !mUp && mCnt == 8'h00;
      ovs = (act && mMode != 2 && mCnt == 8'hFF) || bot;
      nCnt = mCnt;
      if (wc) nCnt = regWdata;
      else if (act) begin
        if (mMode == 0) nCnt = mCnt + 8'd1;
        else if (mMode == 2) begin
          if (mUp) nCnt = (mCnt == 8'hFF) ? 8'hFE : mCnt + 8'd1;
          else     nCnt = (mCnt == 8'h00) ? 8'h01 : mCnt - 8'd1;
        end else nCnt = hit ? 8'h00 : mCnt + 8'd1;
      end
      nUp = mUp;
      if (mMode != 2) nUp = 1'b1;
      else if (top) nUp = 1'b0;
      else if (bot) nUp = 1'b1;
      nAct = mAct;
      if (mMode != 2) nAct = wk ? regWdata : mBuf;
      else if (top) nAct = mBuf;
      nBuf = wk ? regWdata : mBuf;
      nOut = mOut;
      if (hit && mMode == 3) nOut = ~mOut;
      else if (hit && mMode == 2) nOut = mUp ? mInv : ~mInv;
      clrO = (wf && regWdata[0]) || ackOvf;
      clrC = (wf && regWdata[1]) || ackCmp;
      mOvf  = ovs || (mOvf && !clrO);
      mCmpF = hit || (mCmpF && !clrC);
      mCnt = nCnt; mUp = nUp; mAct = nAct; mBuf = nBuf; mOut = nOut;
      if (regWr && regAddr == 3'd0) begin
        mSel = regWdata[2:0]; mMode = regWdata[4:3]; mInv = regWdata[5];
      end
      if (regWr && regAddr == 3'd4) begin
        mMaskO = regWdata[0]; mMaskC = regWdata[1];
      end
      mS3 = mS2; mS2 = mS1; mS1 = extPin;
      mPresc = mPresc + 10'd1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] actual, input logic [7:0] expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, actual, expected, $time);
    end
  endtask

  function automatic string cntTag();
    if (mSel != 3'd1) return "R2";
    case (mMode)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  // lockstep comparison away from the active edge
  always @(negedge clk) begin
    if (checkEn) begin
      case (regAddr)
        3'd1: chk(cntTag(), regRdata, mRead(regAddr));
        3'd2: chk("R7", regRdata, mRead(regAddr));
        3'd3: chk("R9", regRdata, mRead(regAddr));
        default: chk("R13", regRdata, mRead(regAddr));
      endcase
      chk((mMode == 2'd3) ? "R8" : "R6", {7'd0, waveOut}, {7'd0, mOut});
      chk("R11", {7'd0, irqOvf}, {7'd0, mOvf && mMaskO});
      chk("R11", {7'd0, irqCmp}, {7'd0, mCmpF && mMaskC});
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    step();
    regWr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    checkEn = 1'b1;

    // R1: reset state at the ports
    for (int a = 0; a < 5; a++) begin
      regAddr = 3'(a);
      @(negedge clk);
      chk("R1", regRdata, 8'h00);
    end
    chk("R1", {5'd0, waveOut, irqOvf, irqCmp}, 8'h00);
    step();

    // R13: control field layout read back
    wr(3'd0, 8'h3F);
    regAddr = 3'd0;
    @(negedge clk);
    chk("R13", regRdata, 8'h3F);
    step();

    // R10: overflow set and register clear on the same edge
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h01);
    regAddr = 3'd3;
    @(negedge clk);
    chk("R10", regRdata & 8'h01, 8'h01);
    step();
    wr(3'd3, 8'h01);
    regAddr = 3'd3;
    @(negedge clk);
    chk("R10", regRdata & 8'h01, 8'h00);
    step();

    // R12: count write replaces the tick
    wr(3'd1, 8'h40);
    regAddr = 3'd1;
    @(negedge clk);
    chk("R12", regRdata, 8'h40);
    step();

    // R7: PWM buffer readback after write
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h80);
    regAddr = 3'd2;
    @(negedge clk);
    chk("R7", regRdata, 8'h80);
    step();
    repeat (1200) step();

    // R6: inverted PWM run
    wr(3'd0, 8'h31);
    wr(3'd2, 8'h20);
    repeat (1200) step();

    // random traffic
    for (int i = 0; i < 40000; i++) begin
      int r;
      step();
      regWr = 1'b0;
      ackOvf = ($urandom % 16) == 0;
      ackCmp = ($urandom % 16) == 0;
      if (($urandom % 4) == 0) extPin = ~extPin;
      r = $urandom % 128;
      if (r == 0) begin
        logic [2:0] s;
        s = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'd1 + 3'($urandom % 2);
        regWr = 1'b1; regAddr = 3'd0;
        regWdata = {2'b00, 1'($urandom), 2'($urandom), s};
      end else if (r < 3) begin
        regWr = 1'b1; regAddr = 3'd2; regWdata = 8'($urandom);
      end else if (r == 3) begin
        regWr = 1'b1; regAddr = 3'd1; regWdata = ($urandom % 2) ? 8'hFF : 8'($urandom);
      end else if (r == 4) begin
        regWr = 1'b1; regAddr = 3'd3; regWdata = 8'($urandom % 4);
      end else if (r == 5) begin
        regWr = 1'b1; regAddr = 3'd4; regWdata = 8'($urandom % 4);
      end else if (r < 12) begin
        regAddr = 3'($urandom % 6);
      end
    end
    step();
    regWr = 1'b0; ackOvf = 1'b0; ackCmp = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule